// File: doc/BRIEF.md
# Byte-Streaming I2C Target

This block is an I2C target that runs entirely from a fast system clock. It samples the serial clock and data lines through short synchronizer chains and recognises bus conditions from those samples. It collects the address byte that follows a start and checks it against a fixed 7-bit address. After a match it either accepts bytes from the controller or returns bytes to it.

Each byte crosses to the local side over a plain parallel port. A single-cycle write strobe presents each received byte. A single-cycle read strobe marks the moment a byte is taken from the read-data input. Both strobes fire at the rising edge of the acknowledge clock, so an attached device can source or sink an unbroken 8-bit stream.

The data line is open-drain. The block only outputs a pull-low enable and reads the resolved line back. The system clock must run at least eight times faster than the serial clock.

Top module: `i2c_stream_target`

## Requirements
- R1: While reset is asserted and right after it, the SDA pull-low enable is 0 and neither strobe is active.
- R2: A start (SDA falling while SCL is high) puts the target into address reception with the bit count cleared, from any state, including partway through a byte. Bits that were received before the start are discarded.
- R3: A stop (SDA rising while SCL is high) returns the target to idle with SDA released. A stop followed by a start within one SCL high period is seen as both, and the address that follows is served normally.
- R4: A start directly followed by a stop, with no SCL pulse between them, leaves the target idle and not driving SDA. The next transaction is served normally.
- R5: The first byte after a start arrives MSB first. Bits 7..1 are the address, and bit 0 is the direction (1 = controller reads, 0 = controller writes). On a match the target drives SDA low from the SCL falling edge after the 8th bit until the SCL falling edge after the 9th. Mode entry takes effect at the 9th SCL rising edge.
- R6: On an address mismatch the target never drives SDA and issues no strobe until the next start. A valid address after that start is served normally.
- R7: In write mode every data byte is acknowledged as in R5. At the 9th SCL rising edge, wr_stb is high for exactly one system clock, with wr_data holding the byte as received MSB first.
- R8: In read mode rd_stb is high for one system clock at the 9th SCL rising edge of the address byte and of each data byte the controller acknowledges. rd_data is captured in that cycle. Bits are sent MSB first by driving SDA low for a 0, and the drive changes only on SCL falling edges.
- R9: When the controller does not acknowledge a read byte (SDA high at the 9th clock), the target stops driving, issues no further read strobe, and ignores clocks until a stop or a start.
- R10: SCL and SDA each pass through a synchronizer chain of at least two flops. The SDA pull-low enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Resolved serial data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wr_data | output | 8 | Byte received from the controller |
| wr_stb | output | 1 | One-cycle strobe: wr_data is valid |
| rd_data | input | 8 | Next byte to return to the controller |
| rd_stb | output | 1 | One-cycle strobe: rd_data taken |

## Verification
The bench restarts a write partway through a byte. A target that kept its bit count would misalign the next address and miss the acknowledge. It places a stop and a start inside one SCL high period, where a design that lost the second condition would stay idle and never acknowledge. It also sends an empty start-stop frame, which shows whether the target hangs in address reception. A mismatched address followed by data checks that the target stays silent, and a read that ends in a not-acknowledge checks that the target releases SDA and stops requesting bytes. Both rules would show up as a stuck-low line or surplus strobes.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   tx;
        logic [BYTE_W-1:0]   wdata;
        logic                oe;
        logic                wstb;
        logic                rstb;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic now,
    output logic prev
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign now  = sh_q[STAGES-2];
    assign prev = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic scl_now,
    input  logic scl_prev,
    input  logic sda_now,
    input  logic sda_prev,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_held_high;

    always_comb begin
        scl_held_high = scl_now & scl_prev;
        start_ev      = scl_held_high & sda_prev & ~sda_now;
        stop_ev       = scl_held_high & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/i2c_stream_target.sv
module i2c_stream_target
    import i2c_stream_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h42,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_stb
);
    localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);
    localparam int               LINES   = 2;

    logic [LINES-1:0] raw, lv_now, lv_prev;
    logic             scl_now, sda_now, scl_rise, scl_fall;
    logic             start_ev, stop_ev, addr_hit;
    tgt_regs_t        r_d, r_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .now  (lv_now[g]),
            .prev (lv_prev[g])
        );
    end

    assign scl_now  = lv_now[0];
    assign sda_now  = lv_now[1];
    assign scl_rise = lv_now[0] & ~lv_prev[0];
    assign scl_fall = ~lv_now[0] & lv_prev[0];

    i2c_bus_cond u_cond (
        .scl_now (lv_now[0]),
        .scl_prev(lv_prev[0]),
        .sda_now (lv_now[1]),
        .sda_prev(lv_prev[1]),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    assign addr_hit = (r_q.shreg[BYTE_W-1:1] == TARGET_ADDR);

    always_comb begin
        r_d      = r_q;
        r_d.wstb = 1'b0;
        r_d.rstb = 1'b0;
        if (start_ev) begin
            r_d.state = ST_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else if (stop_ev) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else if (scl_rise) begin
            if (r_q.state inside {ST_ADDR, ST_WRITE, ST_READ}) begin
                if (r_q.cnt != ACK_CNT) begin
                    r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_now};
                    r_d.cnt   = r_q.cnt + 1'b1;
                end else begin
                    r_d.cnt = '0;
                    case (r_q.state)
                        ST_ADDR: begin
                            if (!addr_hit) begin
                                r_d.state = ST_IGNORE;
                            end else if (r_q.shreg[0]) begin
                                r_d.state = ST_READ;
                                r_d.rstb  = 1'b1;
                                r_d.tx    = rd_data;
                            end else begin
                                r_d.state = ST_WRITE;
                            end
                        end
                        ST_WRITE: begin
                            r_d.wstb  = 1'b1;
                            r_d.wdata = r_q.shreg;
                        end
                        default: begin
                            if (!sda_now) begin
                                r_d.rstb = 1'b1;
                                r_d.tx   = rd_data;
                            end else begin
                                r_d.state = ST_IGNORE;
                            end
                        end
                    endcase
                end
            end
        end else if (scl_fall) begin
            case (r_q.state)
                ST_ADDR:  r_d.oe = (r_q.cnt == ACK_CNT) && addr_hit;
                ST_WRITE: r_d.oe = (r_q.cnt == ACK_CNT);
                ST_READ: begin
                    if (r_q.cnt != ACK_CNT) begin
                        r_d.oe = ~r_q.tx[BYTE_W-1];
                        r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                    end else begin
                        r_d.oe = 1'b0;
                    end
                end
                default:  r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe  = r_q.oe;
    assign wr_data = r_q.wdata;
    assign wr_stb  = r_q.wstb;
    assign rd_stb  = r_q.rstb;

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> !scl_now);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (r_q.state == ST_ADDR) && (r_q.cnt == '0));

    // R3
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (r_q.state == ST_IDLE) && !r_q.oe);

    // R6
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IGNORE) |-> !r_q.oe && !r_q.wstb && !r_q.rstb);

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wstb |=> !r_q.wstb);

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.rstb |=> !r_q.rstb);
endmodule

// File: tb/test_i2c_stream_target.sv
module test_i2c_stream_target;
    localparam logic [6:0] ADDR = 7'h42;
    localparam int H = 10;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       mst_sda = 1'b1;
    wire        sda_line;
    logic       sda_oe, wr_stb, rd_stb;
    logic [7:0] wr_data, rd_data;

    int         compared = 0, mismatched = 0, cyc = 0, stamp = 0, ridx = 0;
    logic       exp_oe = 1'b0, oe_prev = 1'b0;
    bit         done = 1'b0;
    string      tag = "R1";
    logic [7:0] wq[$];
    logic [7:0] rq[4] = '{8'h3C, 8'h81, 8'hF0, 8'h00};
    logic [7:0] e;

    always #4 clk = ~clk;

    assign sda_line = mst_sda & ~sda_oe;
    assign rd_data  = rq[ridx[1:0]];

    i2c_stream_target #(.TARGET_ADDR(ADDR)) i_i2c_stream_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .wr_data(wr_data), .wr_stb(wr_stb),
        .rd_data(rd_data), .rd_stb(rd_stb));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cyc - stamp > 6) check(sda_oe === exp_oe, tag, "sda_oe", sda_oe, exp_oe);
            if (sda_oe !== oe_prev) check(scl == 1'b0, "R10", "drive change with SCL low", scl, 0);
            oe_prev = sda_oe;
            if (wr_stb) begin
                if (wq.size() == 0) check(1'b0, tag, "unexpected wr_stb", wr_data, 0);
                else begin
                    e = wq.pop_front();
                    check(wr_data == e, "R7", "wr_data", wr_data, e);
                end
            end
            if (rd_stb) ridx++;
        end
    end

    task automatic pause(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive_scl(input logic v, input int n);
        scl = v; stamp = cyc; pause(n);
    endtask

    task automatic drive_sda(input logic v, input int n);
        mst_sda = v; stamp = cyc; pause(n);
    endtask

    task automatic start_cond();
        if (scl == 1'b0) begin
            drive_sda(1'b1, Q);
            drive_scl(1'b1, H);
        end
        exp_oe = 1'b0;
        drive_sda(1'b0, H);
        drive_scl(1'b0, Q);
    endtask

    task automatic stop_cond();
        drive_sda(1'b0, Q);
        drive_scl(1'b1, H);
        exp_oe = 1'b0;
        drive_sda(1'b1, H);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack, input logic nxt,
                             input string req);
        for (int i = 7; i >= 0; i--) begin
            drive_sda(b[i], Q);
            drive_scl(1'b1, H);
            if (i == 0) exp_oe = ack;
            drive_scl(1'b0, Q);
        end
        drive_sda(1'b1, Q);
        drive_scl(1'b1, H / 2);
        check((sda_line == 1'b0) == ack, req, "acknowledge", !sda_line, ack);
        pause(H / 2);
        exp_oe = nxt;
        drive_scl(1'b0, Q);
    endtask

    task automatic recv_byte(input logic [7:0] eb, input logic mack, input logic nxt);
        for (int i = 7; i >= 0; i--) begin
            drive_sda(1'b1, Q);
            drive_scl(1'b1, H / 2);
            check(sda_line == eb[i], "R8", "read bit", sda_line, eb[i]);
            pause(H / 2);
            exp_oe = (i > 0) ? !eb[i-1] : 1'b0;
            drive_scl(1'b0, Q);
        end
        drive_sda(!mack, Q);
        drive_scl(1'b1, H);
        exp_oe = nxt;
        drive_scl(1'b0, Q);
    endtask

    initial begin
        pause(5);
        check(sda_oe == 1'b0 && !wr_stb && !rd_stb, "R1", "reset outputs",
              {sda_oe, wr_stb, rd_stb}, 0);
        rst_n = 1'b1;
        pause(20);
        check(sda_oe == 1'b0 && !wr_stb && !rd_stb, "R1", "idle after reset",
              {sda_oe, wr_stb, rd_stb}, 0);

        // plain write of three bytes
        tag = "R7";
        wq.push_back(8'h11); wq.push_back(8'hC3); wq.push_back(8'h00);
        start_cond();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R5");
        send_byte(8'h11, 1'b1, 1'b0, "R7");
        send_byte(8'hC3, 1'b1, 1'b0, "R7");
        send_byte(8'h00, 1'b1, 1'b0, "R7");
        stop_cond();
        check(wq.size() == 0, "R7", "write bytes delivered", wq.size(), 0);

        // mismatched address, then recovery at next start
        tag = "R6";
        start_cond();
        send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, 1'b0, "R6");
        send_byte(8'h5A, 1'b0, 1'b0, "R6");
        wq.push_back(8'h77);
        start_cond();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R6");
        send_byte(8'h77, 1'b1, 1'b0, "R6");
        stop_cond();
        check(wq.size() == 0, "R6", "write after recovery", wq.size(), 0);

        // start partway through a byte
        tag = "R2";
        start_cond();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 4; i++) begin
            drive_sda(i[0], Q);
            drive_scl(1'b1, H);
            drive_scl(1'b0, Q);
        end
        wq.push_back(8'hA5);
        start_cond();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R2");
        send_byte(8'hA5, 1'b1, 1'b0, "R2");
        stop_cond();
        check(wq.size() == 0, "R2", "byte after restart", wq.size(), 0);

        // stop and start inside one SCL high period
        tag = "R3";
        wq.push_back(8'h3E); wq.push_back(8'h9B);
        start_cond();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R3");
        send_byte(8'h3E, 1'b1, 1'b0, "R3");
        drive_sda(1'b0, Q);
        drive_scl(1'b1, H);
        drive_sda(1'b1, H);
        drive_sda(1'b0, H);
        drive_scl(1'b0, Q);
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R3");
        send_byte(8'h9B, 1'b1, 1'b0, "R3");
        stop_cond();
        check(wq.size() == 0, "R3", "bytes around stop-start", wq.size(), 0);

        // empty frame: start then stop with no clock
        tag = "R4";
        drive_sda(1'b0, H);
        drive_sda(1'b1, H);
        pause(H);
        check(sda_oe == 1'b0, "R4", "released after empty frame", sda_oe, 0);
        wq.push_back(8'h6D);
        start_cond();
        send_byte({ADDR, 1'b0}, 1'b1, 1'b0, "R4");
        send_byte(8'h6D, 1'b1, 1'b0, "R4");
        stop_cond();
        check(wq.size() == 0, "R4", "write after empty frame", wq.size(), 0);

        // read of three bytes, last one not acknowledged
        tag = "R8";
        start_cond();
        send_byte({ADDR, 1'b1}, 1'b1, !rq[0][7], "R5");
        check(ridx == 1, "R8", "strobe on read address", ridx, 1);
        recv_byte(rq[0], 1'b1, !rq[1][7]);
        recv_byte(rq[1], 1'b1, !rq[2][7]);
        tag = "R9";
        recv_byte(rq[2], 1'b0, 1'b0);
        check(ridx == 3, "R8", "read strobe count", ridx, 3);
        send_byte(8'hFF, 1'b0, 1'b0, "R9");
        check(ridx == 3, "R9", "no strobe after NACK", ridx, 3);
        stop_cond();
        pause(H);
        check(sda_oe == 1'b0, "R9", "released after NACK", sda_oe, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule